// File: doc/BRIEF.md
# Biphase Dataline Word Decoder

This block sits behind a data slicer and clock regenerator. It takes already-sampled half-bit symbols, one per pulse of a symbol-enable running at twice the bit rate, together with a gate that is high only while the chosen data line of the first field is present. Inside that gate it pairs the half-bit samples into bits. It then hunts the bit stream for an 8-bit start code, which must appear within a bounded number of bits after the gate opens. Once the code is found, it counts the following frame bits into 8-bit words numbered from 3 upwards.

The frame holds fifteen words: a run-in, the start code, and thirteen payload words. Of the payload, only word 5 and words 11 to 14 are kept. They go into a 40-bit staging register, in the order 11, 12, 13, 14, 5, with each word sent MSB first. A biphase violation in any kept word spoils the whole line. Violations in the run-in, in the start code, or in payload words that are not kept are ignored. When the gate closes, the block emits a single-cycle completion pulse with an error flag. The staging register then holds its value until the gate opens again.

Top module: `dataline_word_decoder`

## Requirements
- R1: During and straight after reset, `line_done` is 0 and `stage` is all ones.
- R2: Symbols are taken only on `sym_en` cycles where `line_gate` is high and was also high on the previous clock. Enables outside that window leave `stage` and the line result unchanged.
- R3: Half-symbols alternate first/second from the opening of the gate. A bit takes the value of its first half. A pair whose two halves are equal is a biphase violation.
- R4: The start code (parameter `START_CODE`, first bit received = MSB) must complete on bit number 8 to `WIN_BITS` of the line. Otherwise the line is abandoned: it reports `line_err`=1 and `stage` stays all ones.
- R5: Biphase violations before or inside the start code do not affect the result.
- R6: After the start code, frame bits map to words 3, 4, 5, … in groups of 8. Word 11 goes to `stage[39:32]`, word 12 to `[31:24]`, word 13 to `[23:16]`, word 14 to `[15:8]` and word 5 to `[7:0]`. The first bit received of each word lands in the word's MSB.
- R7: A biphase violation in word 5 or in words 11 to 14 gives `line_err`=1. Violations in words 3, 4, 6 to 10 and 15 do not.
- R8: If the gate closes before the last bit of word 14 has been received, `line_err` is 1.
- R9: `line_done` is high for exactly one cycle, on the clock after the one where `line_gate` is first seen low. `line_err` is valid with it.
- R10: When `line_gate` rises, `stage` returns to all ones on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_gate | input | 1 | High while the selected data line of the first field is present |
| sym_en | input | 1 | Half-bit sample strobe at twice the bit rate |
| sym_in | input | 1 | Sliced half-bit sample |
| stage | output | 40 | Captured words 11, 12, 13, 14, 5 |
| line_done | output | 1 | One-cycle pulse at the end of a line |
| line_err | output | 1 | Line result, valid with `line_done` (1 = discarded) |

## Verification
Lines are sent with several patterns, and each pattern separates one rule from its neighbours:
- A clean frame checks the word-to-slot mapping.
- A violation placed in the start code, one in the run-in and one in an uncaptured word (word 9) show that these regions are excluded from the error check.
- Violations in word 5 and in word 12 show that both capture regions are included.
- A wrong start code, and start codes pushed to the last bit of the window and beyond it, probe the window bound.
- A line cut short after word 13 probes the completeness rule.
- Stray symbol strobes between lines confirm that the gate qualifies the input.

// File: rtl/dataline_word_decoder.sv
module dataline_word_decoder #(
  parameter logic [7:0] START_CODE = 8'h9B,
  parameter int         WIN_BITS   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_gate,
  input  logic        sym_en,
  input  logic        sym_in,
  output logic [39:0] stage,
  output logic        line_done,
  output logic        line_err
);
  localparam int FRAME_BITS = 96;
  localparam int WIN_W = $clog2(WIN_BITS + 1);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [WIN_W-1:0] WIN_L   = WIN_W'(WIN_BITS);
  localparam logic [WIN_W-1:0] FILL_L  = WIN_W'(7);
  localparam logic [CNT_W-1:0] FRAME_L = CNT_W'(FRAME_BITS);

  logic             gate_d, phase, half0, started, err_q;
  logic [7:0]       sr;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] bit_cnt;
  logic [5:0]       pos;

  wire       active  = gate_d & line_gate;
  wire       bit_v   = half0;
  wire       bip_err = (half0 == sym_in);
  wire [3:0] widx    = bit_cnt[6:3];
  wire       keep    = started && (bit_cnt < FRAME_L) && (widx == 4'd2 || widx >= 4'd8);
  wire       hit     = !started && (win_cnt >= FILL_L) && (win_cnt < WIN_L) &&
                       ({sr[6:0], bit_v} == START_CODE);

  always_comb begin
    if (widx == 4'd2) pos = 6'(7 - int'(bit_cnt[2:0]));
    else              pos = 6'(39 - 8 * (int'(widx) - 8) - int'(bit_cnt[2:0]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d    <= 1'b0;
      phase     <= 1'b0;
      half0     <= 1'b0;
      started   <= 1'b0;
      err_q     <= 1'b0;
      sr        <= '0;
      win_cnt   <= '0;
      bit_cnt   <= '0;
      stage     <= '1;
      line_done <= 1'b0;
      line_err  <= 1'b0;
    end else begin
      gate_d    <= line_gate;
      line_done <= 1'b0;
      if (line_gate && !gate_d) begin
        phase   <= 1'b0;
        started <= 1'b0;
        err_q   <= 1'b0;
        sr      <= '0;
        win_cnt <= '0;
        bit_cnt <= '0;
        stage   <= '1;
      end else if (gate_d && !line_gate) begin
        line_done <= 1'b1;
        line_err  <= !(started && bit_cnt == FRAME_L && !err_q);
      end else if (active && sym_en) begin
        if (!phase) begin
          half0 <= sym_in;
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          if (!started) begin
            sr <= {sr[6:0], bit_v};
            if (win_cnt < WIN_L) win_cnt <= win_cnt + 1'b1;
            if (hit) begin
              started <= 1'b1;
              bit_cnt <= '0;
            end
          end else if (bit_cnt < FRAME_L) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (keep) begin
              stage[pos] <= bit_v;
              if (bip_err) err_q <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

module dataline_word_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_gate,
  input logic [39:0] stage,
  input logic        line_done
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> !$past(line_gate));
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_gate) |-> $stable(stage));
  p_fresh_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_gate) |=> (stage == '1));
  p_no_done_in_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_gate && $past(line_gate)) |-> !line_done);
endmodule

bind dataline_word_decoder dataline_word_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_gate(line_gate), .stage(stage), .line_done(line_done)
);

// File: tb/sim_dataline_word_decoder.sv
module sim_dataline_word_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CODE = 8'h9B;
  localparam int WIN = 24;

  logic clk = 1'b0, rst_n = 1'b0, line_gate = 1'b0, sym_en = 1'b0, sym_in = 1'b0;
  logic [39:0] stage;
  logic line_done, line_err;

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 0;
  string cur_tag = "R6";

  dataline_word_decoder #(.START_CODE(CODE), .WIN_BITS(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .line_gate(line_gate), .sym_en(sym_en), .sym_in(sym_in),
    .stage(stage), .line_done(line_done), .line_err(line_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit m_bits[$];
  bit m_bad[$];
  bit gd = 0, ph = 0, fh = 0, exp_done = 0, exp_err = 0;
  logic [39:0] exp_stage = '1;

  task automatic evaluate();
    int k = -1;
    logic [7:0] win;
    exp_stage = '1;
    exp_err = 1;
    for (int i = 8; i <= WIN && i <= m_bits.size(); i++) begin
      for (int j = 0; j < 8; j++) win[7-j] = m_bits[i-8+j];
      if (win == CODE) begin k = i; break; end
    end
    if (k < 0) return;
    exp_err = (m_bits.size() < k + 96);
    for (int j = 0; j < 96 && k + j < m_bits.size(); j++) begin
      int w = j / 8;
      int b = j % 8;
      if (w == 2 || w >= 8) begin
        if (m_bad[k+j]) exp_err = 1;
        if (w == 2) exp_stage[7-b] = m_bits[k+j];
        else exp_stage[39-8*(w-8)-b] = m_bits[k+j];
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      gd = 0; ph = 0; exp_done = 0; exp_stage = '1;
      m_bits.delete(); m_bad.delete();
    end else begin
      exp_done = 0;
      if (line_gate && !gd) begin
        m_bits.delete(); m_bad.delete(); ph = 0; exp_stage = '1;
      end else if (!line_gate && gd) begin
        evaluate();
        exp_done = 1;
      end else if (line_gate && gd && sym_en) begin
        if (!ph) begin fh = sym_in; ph = 1; end
        else begin m_bits.push_back(fh); m_bad.push_back(fh == sym_in); ph = 0; end
      end
      gd = line_gate;
    end
  end

  task automatic check(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(line_done == exp_done, "R9 line_done", 40'(line_done), 40'(exp_done));
      if (exp_done) begin
        check(line_err == exp_err, {cur_tag, " line_err"}, 40'(line_err), 40'(exp_err));
        check(stage == exp_stage, {cur_tag, " stage"}, stage, exp_stage);
      end else if (!gd) begin
        check(stage == exp_stage, "R2 idle stage", stage, exp_stage);
      end else if (m_bits.size() == 0 && !ph) begin
        check(stage == '1, "R10 stage cleared", stage, '1);
      end
    end
  end

  // stimulus
  task automatic half(bit v);
    sym_en = 1; sym_in = v;
    @(negedge clk);
    sym_en = 0; sym_in = ~v;
    @(negedge clk);
  endtask

  task automatic send_line(int runin, logic [7:0] code, int seed, int last_word,
                           int bad0, int bad1, int bad2);
    logic [7:0] bytes[$];
    int idx = 0;
    for (int i = 0; i < runin; i++) bytes.push_back(8'h55);
    bytes.push_back(code);
    for (int w = 3; w <= last_word; w++) bytes.push_back(8'(w * 37 + seed));
    line_gate = 1;
    repeat (2) @(negedge clk);
    foreach (bytes[n]) begin
      for (int b = 7; b >= 0; b--) begin
        bit v = bytes[n][b];
        bit bad = (idx == bad0) || (idx == bad1) || (idx == bad2);
        half(v);
        half(bad ? v : ~v);
        idx++;
      end
    end
    repeat (2) @(negedge clk);
    line_gate = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(line_done == 0, "R1 line_done", 40'(line_done), 40'h0);
    check(stage == '1, "R1 stage", stage, '1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(stage == '1, "R1 stage after release", stage, '1);

    cur_tag = "R6 clean";            send_line(1, CODE, 1, 15, -1, -1, -1);
    cur_tag = "R5 R3 start/run-in";  send_line(1, CODE, 2, 15, 11, 2, -1);
    cur_tag = "R7 word9 ignored";    send_line(1, CODE, 3, 15, 8*8+2, -1, -1);
    cur_tag = "R7 word15 ignored";   send_line(1, CODE, 4, 15, 14*8+5, -1, -1);
    cur_tag = "R7 word12 error";     send_line(1, CODE, 5, 15, 11*8+4, -1, -1);
    cur_tag = "R7 word5 error";      send_line(1, CODE, 6, 15, 4*8+7, -1, -1);
    cur_tag = "R4 wrong code";       send_line(1, 8'h9A, 7, 15, -1, -1, -1);
    cur_tag = "R4 code at window end"; send_line(2, CODE, 8, 15, -1, -1, -1);
    cur_tag = "R4 code past window"; send_line(3, CODE, 9, 15, -1, -1, -1);
    cur_tag = "R8 short line";       send_line(1, CODE, 10, 13, -1, -1, -1);
    // R2: strobes with the gate low must not disturb anything
    for (int i = 0; i < 20; i++) half(i[0] ^ i[2]);
    repeat (3) @(negedge clk);
    cur_tag = "R2 after stray";      send_line(1, CODE, 11, 15, -1, -1, -1);
    cur_tag = "R6 back to back";     send_line(1, CODE, 12, 15, -1, -1, -1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule